// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block sits between a read requester and a multi-bank SDRAM whose target rows are already open. Each request names a bank and a column. It arrives on a valid/ready handshake. For each accepted request the block drives one READ command onto the command, bank and column pins. It then samples the data bus a selectable CAS latency later and returns the four words of the burst, each marked with its beat number.

A request that stays valid while the previous one is accepted is issued exactly four cycles after it, whatever bank it targets. Because of this spacing the next READ goes out CAS-latency-minus-one cycles before the last word of the current burst, so back-to-back bursts fill the data bus with no idle cycle. Back-pressure exists only on the request side: `req_ready` drops for the three cycles after an acceptance, and the requester must hold bank and column stable while `req_valid` is high and `req_ready` is low. The return path has no ready. The requester must take each word in the cycle `rd_valid` is high. All other cycles carry a NOP, and the data mask stays low.

Top module: `sdr_rd_seq`

## Requirements
- R1: While reset is asserted and before any request, `sd_cmd` is NOP (4'b0111), `req_ready` is 1 and `rd_valid` is 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) puts READ (4'b0101, bits {cs_n, ras_n, cas_n, we_n}) on `sd_cmd` for exactly the following cycle. Every other cycle shows NOP.
- R3: `req_ready` is low in the three cycles that follow an accepting edge and high in all other cycles, so READ commands are at least four cycles apart.
- R4: With `cl_sel`=0 (latency 2) or 1 (latency 3), the DQ bus is sampled at the edge that comes CL edges after the edge where the SDRAM samples the READ. `rd_valid` goes high in the cycle after that sampling edge. `cl_sel` must stay stable while any burst is in flight.
- R5: Each READ returns exactly four words, in four consecutive cycles, with `rd_beat` 0, 1, 2, 3 in order and the data equal to the DQ values of those sampling edges.
- R6: A request held valid is issued exactly four cycles after the previous READ, and the returned data of chained bursts has no idle cycle between bursts.
- R7: The bank and column of each READ equal those of the accepted request. A READ to the same bank as the previous one is spaced and timed exactly like a READ to a different bank.
- R8: `sd_dqm` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_sel | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Requested bank |
| req_col | input | COL_W | Requested starting column |
| sd_cmd | output | 4 | SDRAM command {cs_n, ras_n, cas_n, we_n} |
| sd_bank | output | BANK_W | SDRAM bank address |
| sd_col | output | COL_W | SDRAM column address |
| sd_dqm | output | DQ_W/8 | Data mask, held low |
| sd_dq | input | DQ_W | SDRAM read data bus |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DQ_W | Returned word |
| rd_beat | output | 2 | Beat index of the returned word within its burst |

## Verification
Several properties are checked in every cycle: the command is only ever NOP or READ, READs are at least four cycles apart, `req_ready` falls after each acceptance, an accepted request appears on the pins one cycle later, the beat numbers climb without a break, the first beat comes back at the selected latency, and the mask stays low. Other behaviours can only be shown by the bench's scenarios. These are whether the returned words match what an SDRAM model drove onto DQ at the right edges, whether chained bursts leave no hole on the return path, and how both latencies behave under same-bank and rotating-bank traffic with request gaps of several sizes.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  // Command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    SD_CMD_NOP  = 4'b0111,
    SD_CMD_READ = 4'b0101
  } sd_cmd_e;

  localparam int BURST_LEN = 4;
  localparam int CL_MIN    = 2;
  localparam int CL_MAX    = CL_MIN + 1;
endpackage

// File: rtl/sdr_rd_issue.sv
module sdr_rd_issue
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int COL_W   = 9,
  parameter int SPACING = BURST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic              issue,
  output logic [3:0]        sd_cmd,
  output logic [BANK_W-1:0] sd_bank,
  output logic [COL_W-1:0]  sd_col
);
  localparam int CNT_W = (SPACING > 2) ? $clog2(SPACING) : 1;

  logic [CNT_W-1:0] hold_cnt;
  sd_cmd_e          cmd_q;

  assign req_ready = (hold_cnt == '0);
  assign issue     = req_valid && req_ready;
  assign sd_cmd    = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      cmd_q    <= SD_CMD_NOP;
      sd_bank  <= '0;
      sd_col   <= '0;
    end else begin
      cmd_q <= issue ? SD_CMD_READ : SD_CMD_NOP;
      if (issue) begin
        hold_cnt <= CNT_W'(SPACING - 1);
        sd_bank  <= req_bank;
        sd_col   <= req_col;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_track.sv
module sdr_rd_track #(
  parameter int DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  output logic [DEPTH-1:0] trk
);
  // trk[j] before an edge holds the issue pulse from j+1 edges earlier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk <= '0;
    else        trk <= {trk[DEPTH-2:0], issue};
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture
  import sdr_rd_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int DEPTH = CL_MAX + BURST_LEN,
  parameter int BEATS = BURST_LEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cl_sel,
  input  logic [DEPTH-1:0]         trk,
  input  logic [DQ_W-1:0]          sd_dq,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  output logic [$clog2(BEATS)-1:0] rd_beat
);
  localparam int BEAT_W = $clog2(BEATS);

  logic [BEATS-1:0]  hit;
  logic [BEAT_W-1:0] beat_nx;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign hit[b] = cl_sel ? trk[CL_MAX + b] : trk[CL_MIN + b];
  end

  always_comb begin
    beat_nx = '0;
    for (int b = 0; b < BEATS; b++) begin
      if (hit[b]) beat_nx = BEAT_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_beat  <= '0;
    end else begin
      rd_valid <= |hit;
      if (|hit) begin
        rd_data <= sd_dq;
        rd_beat <= beat_nx;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic [3:0]        sd_cmd,
  output logic [BANK_W-1:0] sd_bank,
  output logic [COL_W-1:0]  sd_col,
  output logic [DQ_W/8-1:0] sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [1:0]        rd_beat
);
  localparam int DEPTH = CL_MAX + BURST_LEN;

  logic             issue;
  logic [DEPTH-1:0] trk;

  assign sd_dqm = '0;

  sdr_rd_issue #(.BANK_W(BANK_W), .COL_W(COL_W), .SPACING(BURST_LEN)) issue_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_ready(req_ready), .issue(issue), .sd_cmd(sd_cmd),
    .sd_bank(sd_bank), .sd_col(sd_col)
  );

  sdr_rd_track #(.DEPTH(DEPTH)) track_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .trk(trk)
  );

  sdr_rd_capture #(.DQ_W(DQ_W), .DEPTH(DEPTH), .BEATS(BURST_LEN)) capture_i (
    .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .trk(trk), .sd_dq(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat)
  );
endmodule

// File: rtl/sdr_rd_seq_chk.sv
module sdr_rd_seq_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int DQ_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cl_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [COL_W-1:0]  req_col,
  input logic [3:0]        sd_cmd,
  input logic [BANK_W-1:0] sd_bank,
  input logic [COL_W-1:0]  sd_col,
  input logic [DQ_W/8-1:0] sd_dqm,
  input logic              rd_valid,
  input logic [1:0]        rd_beat
);
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_READ = 4'b0101;

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_NOP) || (sd_cmd == C_READ)); // R2

  AST_ACCEPT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (sd_cmd == C_READ) && (sd_bank == $past(req_bank)) && (sd_col == $past(req_col))); // R7

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_READ) |-> ($past(sd_cmd) != C_READ) && ($past(sd_cmd, 2) != C_READ) && ($past(sd_cmd, 3) != C_READ)); // R3

  AST_FIRST_BEAT_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_sel && $past(sd_cmd, 3) == C_READ) |-> (rd_valid && rd_beat == 2'd0)); // R4

  AST_FIRST_BEAT_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_sel && $past(sd_cmd, 4) == C_READ) |-> (rd_valid && rd_beat == 2'd0)); // R4

  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != 2'd0) |-> ($past(rd_valid) && $past(rd_beat) == rd_beat - 2'd1)); // R5

  AST_DQM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dqm == '0); // R8
endmodule

bind sdr_rd_seq sdr_rd_seq_chk #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .req_valid(req_valid),
  .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col), .sd_cmd(sd_cmd),
  .sd_bank(sd_bank), .sd_col(sd_col), .sd_dqm(sd_dqm), .rd_valid(rd_valid),
  .rd_beat(rd_beat)
);

// File: tb/sdr_rd_seq_tb.sv
module sdr_rd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cl_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [8:0]  req_col = '0;
  logic [3:0]  sd_cmd;
  logic [1:0]  sd_bank;
  logic [8:0]  sd_col;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_dq = 16'hDEAD;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  rd_beat;

  always #10 clk = ~clk; // 50 MHz

  sdr_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col),
    .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_col(sd_col), .sd_dqm(sd_dqm),
    .sd_dq(sd_dq), .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [1:0] b, input logic [8:0] c, input int i);
    return 16'((b * 16'h1111) ^ (c << 3) ^ (i * 16'h0421) ^ 16'hA5C3);
  endfunction

  // SDRAM model and scoreboard, evaluated mid-cycle
  int          cyc = 0;
  bit          mon_en = 0;
  bit          b2b_mode = 0;
  int          run_rd_cnt = 0;
  int          last_rd = -100;
  bit          pend = 0;
  logic [1:0]  pend_bank;
  logic [8:0]  pend_col;
  logic [15:0] dq_sch [16];
  bit          exp_v  [16];
  logic [15:0] exp_d  [16];
  logic [1:0]  exp_b  [16];
  int          lat, idx;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < 16; i++) begin
      dq_sch[i] = 16'hDEAD; exp_v[i] = 0; exp_d[i] = '0; exp_b[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      lat = cl_sel ? 3 : 2;
      if (pend) begin
        chk(sd_cmd == 4'b0101, "R2 READ after accept", 32'(sd_cmd), 32'h5);
        chk(sd_bank == pend_bank && sd_col == pend_col, "R7 bank/col",
            {21'd0, sd_bank, sd_col}, {21'd0, pend_bank, pend_col});
        if (b2b_mode && run_rd_cnt > 0)
          chk(cyc - last_rd == 4, "R6 chained spacing", 32'(cyc - last_rd), 32'd4);
        last_rd = cyc;
        run_rd_cnt++;
        for (int i = 0; i < 4; i++) begin
          dq_sch[(cyc + lat + i) % 16] = word(pend_bank, pend_col, i);
          idx = (cyc + 1 + lat + i) % 16;
          exp_v[idx] = 1;
          exp_d[idx] = word(pend_bank, pend_col, i);
          exp_b[idx] = 2'(i);
        end
      end else begin
        chk(sd_cmd == 4'b0111, "R2 NOP when idle", 32'(sd_cmd), 32'h7);
      end
      chk(req_ready == (cyc - last_rd >= 3), "R3 ready", 32'(req_ready), 32'(cyc - last_rd >= 3));
      idx = cyc % 16;
      chk(rd_valid == exp_v[idx], b2b_mode ? "R6 return valid" : "R4 return valid",
          32'(rd_valid), 32'(exp_v[idx]));
      if (exp_v[idx] && rd_valid)
        chk(rd_data == exp_d[idx] && rd_beat == exp_b[idx], "R5 data/beat",
            {14'd0, rd_beat, rd_data}, {14'd0, exp_b[idx], exp_d[idx]});
      exp_v[idx] = 0;
      chk(sd_dqm == '0, "R8 dqm", 32'(sd_dqm), 32'd0);
      sd_dq = dq_sch[idx];
      dq_sch[idx] = 16'hDEAD;
      pend = req_valid && req_ready;
      pend_bank = req_bank;
      pend_col = req_col;
    end
  end

  task automatic run_seq(input bit cl, input int n, input int gap, input bit same_bank);
    int k = 0;
    int idle = 0;
    @(posedge clk); #2;
    cl_sel = cl;
    b2b_mode = (gap == 0);
    run_rd_cnt = 0;
    while (k < n) begin
      if (idle > 0) begin
        req_valid = 1'b0;
        idle--;
      end else begin
        req_valid = 1'b1;
        req_bank = same_bank ? 2'd2 : 2'(k);
        req_col = 9'((k * 37 + gap * 5 + cl * 100) & 511);
      end
      @(negedge clk);
      if (req_valid && req_ready) begin
        k++;
        idle = gap;
      end
      @(posedge clk); #2;
    end
    req_valid = 1'b0;
    repeat (14) @(posedge clk);
    #2;
    b2b_mode = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sd_cmd == 4'b0111, "R1 reset cmd", 32'(sd_cmd), 32'h7);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    chk(rd_valid == 1'b0, "R1 reset valid", 32'(rd_valid), 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_cmd == 4'b0111 && req_ready && !rd_valid, "R1 idle after reset",
        {28'd0, sd_cmd}, 32'h7);
    mon_en = 1;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 2; s++)
        foreach (gap_set[g])
          run_seq(c[0], 10, gap_set[g], s[0]);
    finish_run();
  end

  int gap_set [4] = '{0, 1, 3, 5};
endmodule